// File: doc/BRIEF.md
# Four-Instruction Multicycle Accumulator Processor

This block is a small multicycle processor. It runs a program held in a word-addressed main memory. It has one working data register, called the accumulator here. Every instruction works from memory into that register. The instruction set has four operations: load a memory word into the accumulator, store the accumulator into memory, add a memory word into the accumulator, and stop.

The memory is reached only through two registers. The address register drives the address bus. The data register captures read data and holds write data. The sequencer steps through the fetch, decode and execute phases, and each step takes its own clock cycle. A status register records the zero and carry results of the last add, and an error bit for an unrecognised opcode.

The block is meant to sit next to a single-port memory. That memory answers a read request one cycle after the request. The integrator loads a program at word 0 and releases reset. The program runs until the stop instruction, and the block then raises its halted output.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted (synchronous, active low), and on the first cycle after it: no memory request, halted low, status all zero. The first request after reset is a read of address 0.
- R2: A memory request lasts exactly one cycle. A request is always followed by at least one cycle without a request.
- R3: A store issues one write request. On that request, the address is the operand field of the instruction and the write data is the accumulator value.
- R4: Load (opcode 0x01) puts the addressed memory word into the accumulator and leaves the zero and carry flags unchanged.
- R5: Add (opcode 0x03) puts the 32-bit wrapped sum of the accumulator and the addressed word into the accumulator. It sets status bit 1 (carry) to the carry out of the sum, and status bit 0 (zero) when the result is zero.
- R6: Store (opcode 0x02) leaves the zero and carry flags unchanged.
- R7: Instructions are fetched by a read request at the program counter. The program counter advances by exactly 1 after each completed instruction, so the fetch addresses are consecutive.
- R8: Stop (opcode 0x00) raises halted. The block then issues no further memory requests, and halted stays high until reset.
- R9: Any other opcode acts as stop and also sets status bit 2 (error).
- R10: An instruction word carries the opcode in bits 31:24 and a word address in bits 23:0. Load and add read memory at that address.
- R11: A reset applied in the middle of a program clears the flags and the halted output, and execution starts again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 24 | Memory address, driven from the address register |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | Write enable, valid while mem_req is high |
| mem_wdata | output | 32 | Write data, driven from the data register |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| halted | output | 1 | High once the stop instruction or an unknown opcode has been executed |
| status | output | 3 | {error, carry, zero} |

## Verification
The hardest state to reach is one where the flags have already been set and the instructions that follow must leave them alone. An add that wraps to zero sets both zero and carry. After it, a store and a load of a nonzero word run, and the final status must still read both flags set. A second hard case is a reset that arrives after the add has set the flags but before the program ends. The bench counts cycles from reset so that this reset lands after the add's writeback. It then checks that the flags and the halted output are clear and that the fetch order starts again from address 0.

// File: rtl/acc_cpu_pkg.sv
// Shared types for the accumulator processor: opcodes, sequencer states
// and the control word that the sequencer sends to the datapath.
// Assumes an 8-bit opcode field at the top of every instruction word.
package acc_cpu_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [OPC_W-1:0] {
        OP_STOP  = 8'h00,
        OP_LOAD  = 8'h01,
        OP_STORE = 8'h02,
        OP_ADD   = 8'h03
    } opcode_e;

    typedef enum logic [3:0] {
        S_FETCH_ADDR,
        S_FETCH_REQ,
        S_FETCH_CAP,
        S_FETCH_IR,
        S_DECODE,
        S_EXEC_REQ,
        S_EXEC_CAP,
        S_EXEC_WB,
        S_NEXT,
        S_HALT
    } state_e;

    typedef struct packed {
        logic mar_pc;   // address register <- program counter
        logic mar_ir;   // address register <- instruction operand
        logic mdr_bus;  // data register <- memory read data
        logic mdr_d0;   // data register <- accumulator
        logic ir_ld;    // instruction register <- data register
        logic d0_ld;    // accumulator <- data register
        logic d0_add;   // accumulator <- accumulator + data register
        logic pc_inc;   // program counter + 1
        logic err_set;  // set the error status bit
        logic req;      // memory request
        logic we;       // memory write
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// Adder for the accumulator. It returns the wrapped sum, the carry out and
// a zero indication. Purely combinational; the operands are unsigned.
module acc_cpu_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         zero
);

    // Add with one extra bit to keep the carry out.
    always_comb begin
        {carry, sum} = {1'b0, a} + {1'b0, b};
        zero = (sum == '0);
    end

endmodule

// File: rtl/acc_cpu_seq.sv
// Fetch/decode/execute sequencer. Each phase takes one state, so every
// memory access goes address register -> request -> data register in
// separate cycles. Assumes read data arrives one cycle after the request.
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output ctl_t             ctl,
    output logic             halted
);

    state_e state, nxt;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH_ADDR;
        else        state <= nxt;
    end

    // Next state and control word for the current step.
    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            S_FETCH_ADDR: begin ctl.mar_pc = 1'b1;  nxt = S_FETCH_REQ; end
            S_FETCH_REQ:  begin ctl.req = 1'b1;     nxt = S_FETCH_CAP; end
            S_FETCH_CAP:  begin ctl.mdr_bus = 1'b1; nxt = S_FETCH_IR;  end
            S_FETCH_IR:   begin ctl.ir_ld = 1'b1;   nxt = S_DECODE;    end
            S_DECODE: begin
                case (opcode)
                    OP_LOAD, OP_ADD: begin
                        ctl.mar_ir = 1'b1;
                        nxt = S_EXEC_REQ;
                    end
                    OP_STORE: begin
                        ctl.mar_ir = 1'b1;
                        ctl.mdr_d0 = 1'b1;
                        nxt = S_EXEC_REQ;
                    end
                    OP_STOP: nxt = S_HALT;
                    default: begin
                        ctl.err_set = 1'b1;
                        nxt = S_HALT;
                    end
                endcase
            end
            S_EXEC_REQ: begin
                ctl.req = 1'b1;
                if (opcode == OP_STORE) begin
                    ctl.we = 1'b1;
                    nxt = S_NEXT;
                end else begin
                    nxt = S_EXEC_CAP;
                end
            end
            S_EXEC_CAP: begin ctl.mdr_bus = 1'b1; nxt = S_EXEC_WB; end
            S_EXEC_WB: begin
                if (opcode == OP_ADD) ctl.d0_add = 1'b1;
                else                  ctl.d0_ld  = 1'b1;
                nxt = S_NEXT;
            end
            S_NEXT:  begin ctl.pc_inc = 1'b1; nxt = S_FETCH_ADDR; end
            S_HALT:  nxt = S_HALT;
            default: nxt = S_FETCH_ADDR;
        endcase
    end

    assign halted = (state == S_HALT);

endmodule

// File: rtl/acc_cpu_dp.sv
// Datapath: program counter, instruction register, memory address and
// data registers, accumulator and status register. It acts only on the
// control word; it takes no decisions of its own.
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [OPC_W-1:0]  opcode,
    output logic [2:0]        sr
);

    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir, d0, sum;
    logic              carry, zero;

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .a(d0), .b(mdr), .sum(sum), .carry(carry), .zero(zero)
    );

    // Program counter: starts at 0 and moves one word per instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (ctl.pc_inc) pc <= pc + 1'b1;
    end

    // Address register: loaded from the PC for a fetch, from the IR operand for data.
    always_ff @(posedge clk) begin
        if (!rst_n)          mar <= '0;
        else if (ctl.mar_pc) mar <= pc;
        else if (ctl.mar_ir) mar <= ir[ADDR_W-1:0];
    end

    // Data register: captures read data, or takes the accumulator for a store.
    always_ff @(posedge clk) begin
        if (!rst_n)           mdr <= '0;
        else if (ctl.mdr_bus) mdr <= mem_rdata;
        else if (ctl.mdr_d0)  mdr <= d0;
    end

    // Instruction register: held through decode and execute.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir <= '0;
        else if (ctl.ir_ld) ir <= mdr;
    end

    // Accumulator: a load or an add result.
    always_ff @(posedge clk) begin
        if (!rst_n)          d0 <= '0;
        else if (ctl.d0_ld)  d0 <= mdr;
        else if (ctl.d0_add) d0 <= sum;
    end

    // Status register {error, carry, zero}: flags change only on an add.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else begin
            if (ctl.d0_add)  sr[1:0] <= {carry, zero};
            if (ctl.err_set) sr[2]   <= 1'b1;
        end
    end

    assign opcode = ir[DATA_W-1 -: OPC_W];

    // Assertion support: high from the second cycle after reset is released.
    logic chk_ok;
    always_ff @(posedge clk) chk_ok <= rst_n;

    // R2
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.req |=> !ctl.req);

    // R3
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.we |-> (mdr == d0 && mar == ir[ADDR_W-1:0]));

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.d0_add |=> (sr[0] == (d0 == '0)));

    // R4, R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.d0_ld || ctl.mdr_d0) |=> $stable(sr[1:0]));

endmodule

// File: rtl/acc_cpu.sv
// Top of the accumulator processor. It joins the sequencer and the
// datapath and drives the memory bus straight from the address and data
// registers. Assumes a single-port memory with one cycle of read latency.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [OPC_W+ADDR_W-1:0] mem_wdata,
    input  logic [OPC_W+ADDR_W-1:0] mem_rdata,
    output logic                    halted,
    output logic [2:0]              status
);

    localparam int DATA_W = OPC_W + ADDR_W;

    ctl_t             ctl;
    logic [OPC_W-1:0] opcode;

    acc_cpu_seq u_seq (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ctl(ctl), .halted(halted)
    );

    acc_cpu_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
        .mar(mem_addr), .mdr(mem_wdata), .opcode(opcode), .sr(status)
    );

    assign mem_req = ctl.req;
    assign mem_we  = ctl.we;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !halted && status == 3'b000));

    // R3
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_req));

    // R9
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> halted);

endmodule

// File: tb/tb_acc_cpu.sv
// Scoreboard bench: driver tasks queue the bus transactions that each
// program should produce; a monitor pops and compares them as they occur.
module tb_acc_cpu;

    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_req, mem_we, halted;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [2:0]    status;

    always #5 clk = ~clk;

    acc_cpu dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .status(status)
    );

    // Memory model: 64 words, read data one cycle after the request.
    logic [DW-1:0] mem [0:63];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[5:0]];
        end
    end

    typedef struct packed {
        logic          we;
        logic [1:0]    kind;   // 0 fetch, 1 operand read, 2 store
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } txn_t;

    txn_t expq[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver tasks: queue expected bus traffic.
    task automatic exp_fetch(input int a);
        expq.push_back({1'b0, 2'd0, AW'(a), DW'(0)});
    endtask
    task automatic exp_read(input int a);
        expq.push_back({1'b0, 2'd1, AW'(a), DW'(0)});
    endtask
    task automatic exp_write(input int a, input logic [DW-1:0] d);
        expq.push_back({1'b1, 2'd2, AW'(a), d});
    endtask

    function automatic logic [DW-1:0] ins(input logic [7:0] op, input int a);
        return {op, AW'(a)};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    // Monitor: compares each request against the head of the queue.
    logic prev_req = 1'b0;
    always @(negedge clk) begin
        txn_t t;
        if (rst_n && mem_req) begin
            // R2: no back-to-back requests
            check(!prev_req, "R2 back-to-back request", {8'h0, mem_addr}, 0);
            if (expq.size() == 0) begin
                check(1'b0, "R8 unexpected request", {8'h0, mem_addr}, 0);
            end else begin
                t = expq.pop_front();
                case (t.kind)
                    2'd0: check(!mem_we && mem_addr == t.addr, "R7 fetch address",
                                {7'h0, mem_we, mem_addr}, {8'h0, t.addr});
                    2'd1: check(!mem_we && mem_addr == t.addr, "R10 operand read address",
                                {7'h0, mem_we, mem_addr}, {8'h0, t.addr});
                    default: begin
                        check(mem_we && mem_addr == t.addr, "R3 store address",
                              {7'h0, mem_we, mem_addr}, {8'h1, t.addr});
                        check(mem_wdata == t.data, "R3 store data", mem_wdata, t.data);
                    end
                endcase
            end
        end
        prev_req = rst_n && mem_req;
    end

    // Reset and check the quiet state (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!mem_req && !halted && status == 3'b000, "R1 reset state",
              {28'h0, mem_req, halted, status[1:0]}, 0);
        rst_n = 1'b1;
    endtask

    // Run to halt, then confirm it stays halted with no traffic (R8).
    task automatic run_to_halt(input string tag);
        int n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (12) @(negedge clk);
        check(halted, {tag, " halted stays high"}, DW'(halted), 1);
        check(expq.size() == 0, {tag, " all expected transactions seen"},
              DW'(expq.size()), 0);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // Scenario A: Z = X + Y, small values (R4, R5, R7, R8, R10).
        clear_mem();
        mem[0] = ins(8'h01, 16); mem[1] = ins(8'h03, 17);
        mem[2] = ins(8'h02, 18); mem[3] = ins(8'h00, 0);
        mem[16] = 32'd5; mem[17] = 32'd7;
        expq.delete();
        exp_fetch(0); exp_read(16); exp_fetch(1); exp_read(17);
        exp_fetch(2); exp_write(18, 32'd12); exp_fetch(3);
        do_reset();
        // R1: first request after reset is a read of 0 (checked as the first fetch)
        run_to_halt("R8");
        check(mem[18] == 32'd12, "R5 Z = X + Y", mem[18], 32'd12);
        check(status == 3'b000, "R5 flags clear", DW'(status), 0);

        // Scenario B: wrapping add, then store and load keep flags (R4, R5, R6).
        clear_mem();
        mem[0] = ins(8'h01, 16); mem[1] = ins(8'h03, 17);
        mem[2] = ins(8'h02, 18); mem[3] = ins(8'h01, 20);
        mem[4] = ins(8'h02, 21); mem[5] = ins(8'h00, 0);
        mem[16] = 32'hFFFF_FFFF; mem[17] = 32'd1; mem[18] = 32'hDEAD_BEEF;
        mem[20] = 32'h55;
        expq.delete();
        exp_fetch(0); exp_read(16); exp_fetch(1); exp_read(17);
        exp_fetch(2); exp_write(18, 32'd0); exp_fetch(3); exp_read(20);
        exp_fetch(4); exp_write(21, 32'h55); exp_fetch(5);
        do_reset();
        run_to_halt("R8");
        check(mem[18] == 32'd0, "R5 wrapped sum", mem[18], 0);
        check(mem[21] == 32'h55, "R4 load value", mem[21], 32'h55);
        check(status == 3'b011, "R6 R4 flags kept after store and load",
              DW'(status), 3'b011);

        // Scenario C: unknown opcode halts and flags an error (R9).
        clear_mem();
        mem[0] = ins(8'h01, 16); mem[1] = ins(8'h02, 18);
        mem[2] = ins(8'h7F, 0);  mem[3] = ins(8'h02, 19);
        mem[16] = 32'hA5A5_A5A5;
        expq.delete();
        exp_fetch(0); exp_read(16); exp_fetch(1); exp_write(18, 32'hA5A5_A5A5);
        exp_fetch(2);
        do_reset();
        run_to_halt("R9");
        check(status == 3'b100, "R9 error bit set", DW'(status), 3'b100);
        check(mem[19] == 32'd0, "R9 later store not executed", mem[19], 0);

        // Scenario D: reset after the add has set flags (R11).
        clear_mem();
        mem[0] = ins(8'h01, 16); mem[1] = ins(8'h03, 17);
        mem[2] = ins(8'h02, 18); mem[3] = ins(8'h00, 0);
        mem[16] = 32'h8000_0000; mem[17] = 32'h8000_0000;
        expq.delete();
        exp_fetch(0); exp_read(16); exp_fetch(1); exp_read(17); exp_fetch(2);
        do_reset();
        repeat (20) @(negedge clk);
        check(status == 3'b011, "R5 carry and zero before reset", DW'(status), 3'b011);
        check(!halted, "R11 still running before reset", DW'(halted), 0);
        expq.delete();
        // Restart with new data; the fetch order must begin at 0 again.
        mem[16] = 32'h1234_5678; mem[17] = 32'h1111_1111;
        exp_fetch(0); exp_read(16); exp_fetch(1); exp_read(17);
        exp_fetch(2); exp_write(18, 32'h2345_6789); exp_fetch(3);
        do_reset();
        check(status == 3'b000 && !halted, "R11 flags and halt cleared by reset",
              {28'h0, halted, status}, 0);
        run_to_halt("R11");
        check(mem[18] == 32'h2345_6789, "R11 program reruns from start",
              mem[18], 32'h2345_6789);
        check(status == 3'b000, "R5 no carry, nonzero", DW'(status), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule